// File: doc/BRIEF.md
# Legacy BIOS Alias Address Decoder

This block sits on the path from the processor's physical address to the memory targets. For each access it looks at the 32-bit address and the read/write strobe. It then picks one target: DRAM, the boot ROM, or no target at all. It also produces the byte offset into the ROM.

The ROM occupies the top of the 4 GB space, so the reset fetch at 0xFFFFFFF0 lands in it. The last 128 KB of the ROM also appears in the legacy window from 0x000E0000 to 0x000FFFFF. A low-window address and its counterpart near 4 GB select the same ROM byte.

The legacy window is divided into eight 16 KB sub-ranges, each with a 2-bit attribute. The attribute routes reads and writes in that sub-range either to the ROM or to DRAM. Firmware uses this to copy itself into DRAM: it sends reads to the ROM and writes to DRAM, and then sends both to DRAM. A build option limits control to reads only. In that case, low-window writes always go to DRAM.

Top module: `bios_alias_decoder`

## Requirements
- R1: With `valid_i` high, any address at or above ROM_BASE (default 0xFFFC0000, a 256 KB ROM) gives `tgt_o`=2 (ROM) and `rom_off_o` = address − ROM_BASE. For example, 0xFFFFFFF0 gives offset 0x3FFF0.
- R2: An access in 0x000E0000–0x000FFFFF that is routed to ROM gives `rom_off_o` = ROM size − 128 KB + address[16:0]. This is the same offset as the alias address 0xFFFE0000 + address[16:0].
- R3: After reset every attribute is zero, so low-window reads and writes both target the ROM (2).
- R4: The sub-range index is address[16:14]. When bit 0 of that sub-range's attribute is set, reads there go to DRAM (1) with `rom_off_o`=0. Other sub-ranges are not affected.
- R5: With RD_ONLY_CTRL=0, when bit 1 of the sub-range attribute is set, writes there go to DRAM. When that bit is clear, writes there go to the ROM.
- R6: With RD_ONLY_CTRL=1, low-window writes always go to DRAM whatever the attribute holds. Reads still follow bit 0.
- R7: `wr_drop_o` is 1 exactly when a valid write targets the ROM, in either window.
- R8: A valid access outside both ROM windows goes to DRAM (1) if the address is below DRAM_TOP (default 0x40000000). Otherwise it gets no target (0) with `rom_off_o`=0.
- R9: A `cfg_we_i` pulse stores `cfg_attr_i` into sub-range `cfg_idx_i` at the next rising clock edge. Routing uses the new value from then on, and the other sub-ranges keep their values.
- R10: With `valid_i` low, `tgt_o` is 0 and `wr_drop_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Access present this cycle |
| addr_i | input | 32 | Physical address |
| wr_i | input | 1 | 1 = write, 0 = read |
| cfg_we_i | input | 1 | Attribute write strobe |
| cfg_idx_i | input | 3 | Sub-range selected for the attribute write |
| cfg_attr_i | input | 2 | New attribute: bit0 reads to DRAM, bit1 writes to DRAM |
| tgt_o | output | 2 | Target: 0 none, 1 DRAM, 2 ROM |
| rom_off_o | output | 18 | ROM byte offset, 0 unless the target is ROM |
| wr_drop_o | output | 1 | Write to ROM discarded |

## Verification
The assertions assume three things about the inputs:
- `addr_i`, `wr_i` and `valid_i` are steady around each clock edge.
- `cfg_idx_i` always names one of the eight sub-ranges.
- Attribute writes are not mixed with decode checks in the same cycle.

The bench meets these assumptions in the following way:
- It changes every input on the falling edge.
- It samples outputs one nanosecond later.
- It performs each attribute write as a single-cycle pulse and then returns the strobe low before it probes addresses.

A second instance built with read-only control covers the restricted-write variant under the same conditions.

// File: rtl/bad_pkg.sv
package bad_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DRAM = 2'd1,
    TGT_ROM  = 2'd2
  } tgt_e;
endpackage

// File: rtl/bad_attr_regs.sv
module bad_attr_regs #(
  parameter int NUM_SUB = 8,
  localparam int IDX_W = $clog2(NUM_SUB)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [IDX_W-1:0]       cfg_idx_i,
  input  logic [1:0]             cfg_attr_i,
  output logic [NUM_SUB-1:0][1:0] attr_o
);
  for (genvar k = 0; k < NUM_SUB; k++) begin : g_sub
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   attr_o[k] <= 2'b00;
      else if (cfg_we_i && cfg_idx_i == IDX_W'(k))   attr_o[k] <= cfg_attr_i;
    end

    // R9
    attr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_idx_i == IDX_W'(k)) |=> attr_o[k] == $past(cfg_attr_i));
    // R9
    attr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(cfg_we_i && cfg_idx_i == IDX_W'(k)) |=> $stable(attr_o[k]));
  end
endmodule

// File: rtl/bad_window_match.sv
module bad_window_match #(
  parameter int          ADDR_W      = 32,
  parameter int          ROM_AW      = 18,
  parameter int          ALIAS_AW    = 17,
  parameter int          SUB_AW      = 14,
  parameter logic [31:0] LEGACY_BASE = 32'h000E_0000,
  parameter logic [31:0] DRAM_TOP    = 32'h4000_0000,
  localparam int         IDX_W       = ALIAS_AW - SUB_AW
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hi_hit_o,
  output logic              lo_hit_o,
  output logic              dram_ok_o,
  output logic [IDX_W-1:0]  sub_idx_o,
  output logic [ROM_AW-1:0] hi_off_o,
  output logic [ROM_AW-1:0] lo_off_o
);
  localparam logic [ADDR_W-ALIAS_AW-1:0] LO_TAG =
    (ADDR_W-ALIAS_AW)'(LEGACY_BASE >> ALIAS_AW);
  // last 128 KB of the ROM starts at this offset
  localparam logic [ROM_AW-1:0] LO_BASE_OFF =
    ROM_AW'((64'd1 << ROM_AW) - (64'd1 << ALIAS_AW));

  assign hi_hit_o  = &addr_i[ADDR_W-1:ROM_AW];
  assign lo_hit_o  = addr_i[ADDR_W-1:ALIAS_AW] == LO_TAG;
  assign dram_ok_o = addr_i < ADDR_W'(DRAM_TOP);
  assign sub_idx_o = addr_i[ALIAS_AW-1:SUB_AW];
  assign hi_off_o  = addr_i[ROM_AW-1:0];
  assign lo_off_o  = LO_BASE_OFF + ROM_AW'(addr_i[ALIAS_AW-1:0]);
endmodule

// File: rtl/bios_alias_decoder.sv
module bios_alias_decoder #(
  parameter int          ADDR_W       = 32,
  parameter int          ROM_AW       = 18,
  parameter int          ALIAS_AW     = 17,
  parameter int          SUB_AW       = 14,
  parameter logic [31:0] LEGACY_BASE  = 32'h000E_0000,
  parameter logic [31:0] DRAM_TOP     = 32'h4000_0000,
  parameter bit          RD_ONLY_CTRL = 1'b0,
  localparam int         IDX_W        = ALIAS_AW - SUB_AW,
  localparam int         NUM_SUB      = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [1:0]        cfg_attr_i,
  output logic [1:0]        tgt_o,
  output logic [ROM_AW-1:0] rom_off_o,
  output logic              wr_drop_o
);
  import bad_pkg::*;

  logic [NUM_SUB-1:0][1:0] attr;
  logic                    hi_hit, lo_hit, dram_ok;
  logic [IDX_W-1:0]        sub_idx;
  logic [ROM_AW-1:0]       hi_off, lo_off;
  logic [1:0]              cur_attr;
  logic                    lo_to_dram;
  tgt_e                    tgt;

  bad_attr_regs #(.NUM_SUB(NUM_SUB)) u_attr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_attr_i (cfg_attr_i),
    .attr_o     (attr)
  );

  bad_window_match #(
    .ADDR_W(ADDR_W), .ROM_AW(ROM_AW), .ALIAS_AW(ALIAS_AW), .SUB_AW(SUB_AW),
    .LEGACY_BASE(LEGACY_BASE), .DRAM_TOP(DRAM_TOP)
  ) u_match (
    .addr_i    (addr_i),
    .hi_hit_o  (hi_hit),
    .lo_hit_o  (lo_hit),
    .dram_ok_o (dram_ok),
    .sub_idx_o (sub_idx),
    .hi_off_o  (hi_off),
    .lo_off_o  (lo_off)
  );

  assign cur_attr = attr[sub_idx];

  // read-only control variant forces writes to DRAM
  if (RD_ONLY_CTRL) begin : g_rd_only
    assign lo_to_dram = wr_i ? (cur_attr[1] | 1'b1) : cur_attr[0];
  end else begin : g_rd_wr
    assign lo_to_dram = wr_i ? cur_attr[1] : cur_attr[0];
  end

  always_comb begin
    tgt       = TGT_NONE;
    rom_off_o = '0;
    if (valid_i) begin
      if (hi_hit) begin
        tgt       = TGT_ROM;
        rom_off_o = hi_off;
      end else if (lo_hit && !lo_to_dram) begin
        tgt       = TGT_ROM;
        rom_off_o = lo_off;
      end else if (lo_hit || dram_ok) begin
        tgt       = TGT_DRAM;
      end
    end
  end

  assign tgt_o     = tgt;
  assign wr_drop_o = valid_i && wr_i && (tgt == TGT_ROM);

  // R1
  hi_rom_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i >= ADDR_W'(32'hFFFF_FFFF - ((32'd1 << ROM_AW) - 1)))
      |-> (tgt_o == 2'd2 && rom_off_o == addr_i[ROM_AW-1:0]));
  // R7
  drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_drop_o |-> (valid_i && wr_i && tgt_o == 2'd2));
  // R8
  none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && tgt_o == 2'd0) |-> (addr_i >= ADDR_W'(DRAM_TOP) && rom_off_o == '0));
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (tgt_o == 2'd0 && !wr_drop_o));
  // R6
  rd_only_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (RD_ONLY_CTRL && valid_i && wr_i && lo_hit) |-> tgt_o == 2'd1);
endmodule

// File: tb/bios_alias_decoder_bench.sv
module bios_alias_decoder_bench;
  typedef struct packed {
    logic [31:0] a;
    logic        w;
    logic [1:0]  t;
    logic [17:0] o;
    logic        d;
  } vec_t;

  localparam int NV = 11;
  // reset attributes: low window goes to ROM for reads and writes
  localparam vec_t VECS [NV] = '{
    '{32'hFFFF_FFF0, 1'b0, 2'd2, 18'h3FFF0, 1'b0}, // R1 reset fetch
    '{32'hFFFC_0000, 1'b0, 2'd2, 18'h00000, 1'b0}, // R1 base
    '{32'h000F_0000, 1'b0, 2'd2, 18'h30000, 1'b0}, // R2 R3
    '{32'hFFFF_0000, 1'b0, 2'd2, 18'h30000, 1'b0}, // R2 alias match
    '{32'h000E_0000, 1'b1, 2'd2, 18'h20000, 1'b1}, // R3 R7
    '{32'h000F_FFFF, 1'b0, 2'd2, 18'h3FFFF, 1'b0}, // R2
    '{32'h000D_FFFF, 1'b0, 2'd1, 18'h00000, 1'b0}, // R8
    '{32'h0010_0000, 1'b0, 2'd1, 18'h00000, 1'b0}, // R8
    '{32'h3FFF_FFFF, 1'b1, 2'd1, 18'h00000, 1'b0}, // R8 R7
    '{32'h4000_0000, 1'b0, 2'd0, 18'h00000, 1'b0}, // R8 none
    '{32'hFFFF_FFF0, 1'b1, 2'd2, 18'h3FFF0, 1'b1}  // R7 high write
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        wr_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_idx_i = '0;
  logic [1:0]  cfg_attr_i = '0;
  logic [1:0]  tgt_o, tgt_ro;
  logic [17:0] rom_off_o, off_ro;
  logic        wr_drop_o, drop_ro;
  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  bios_alias_decoder u_bios_alias_decoder (
    .clk_i, .rst_ni, .valid_i, .addr_i, .wr_i, .cfg_we_i, .cfg_idx_i, .cfg_attr_i,
    .tgt_o, .rom_off_o, .wr_drop_o
  );

  bios_alias_decoder #(.RD_ONLY_CTRL(1'b1)) u_bios_alias_decoder_ro (
    .clk_i, .rst_ni, .valid_i, .addr_i, .wr_i, .cfg_we_i, .cfg_idx_i, .cfg_attr_i,
    .tgt_o(tgt_ro), .rom_off_o(off_ro), .wr_drop_o(drop_ro)
  );

  task automatic probe(input logic v, input logic [31:0] a, input logic w,
                       input logic [1:0] et, input logic [17:0] eo, input logic ed,
                       input string req);
    @(negedge clk_i);
    valid_i = v; addr_i = a; wr_i = w;
    #1;
    total++;
    if (tgt_o !== et || rom_off_o !== eo || wr_drop_o !== ed) begin
      bad++;
      $display("FAIL %s addr=%h wr=%0d: got tgt=%0d off=%h drop=%0d exp tgt=%0d off=%h drop=%0d",
               req, a, w, tgt_o, rom_off_o, wr_drop_o, et, eo, ed);
    end
  endtask

  task automatic probe_ro(input logic [31:0] a, input logic w,
                          input logic [1:0] et, input logic ed, input string req);
    @(negedge clk_i);
    valid_i = 1'b1; addr_i = a; wr_i = w;
    #1;
    total++;
    if (tgt_ro !== et || drop_ro !== ed) begin
      bad++;
      $display("FAIL %s ro addr=%h wr=%0d: got tgt=%0d drop=%0d exp tgt=%0d drop=%0d",
               req, a, w, tgt_ro, drop_ro, et, ed);
    end
  endtask

  task automatic set_attr(input logic [2:0] idx, input logic [1:0] v);
    @(negedge clk_i);
    valid_i = 1'b0; cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_attr_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset/idle state
    probe(1'b0, 32'hFFFF_FFF0, 1'b1, 2'd0, 18'h0, 1'b0, "R10");
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++)
      probe(1'b1, VECS[i].a, VECS[i].w, VECS[i].t, VECS[i].o, VECS[i].d, "R1/R2/R3/R7/R8 table");

    // R4: sub-range 4 (0xF0000) reads to DRAM
    set_attr(3'd4, 2'b01);
    probe(1'b1, 32'h000F_0000, 1'b0, 2'd1, 18'h0, 1'b0, "R4 R9");
    probe(1'b1, 32'h000F_3FFF, 1'b1, 2'd2, 18'h33FFF, 1'b1, "R5");
    probe(1'b1, 32'h000E_C000, 1'b0, 2'd2, 18'h2C000, 1'b0, "R4 R9 neighbour");
    probe(1'b1, 32'h000F_4000, 1'b0, 2'd2, 18'h34000, 1'b0, "R4 R9 neighbour");
    probe(1'b1, 32'hFFFF_0000, 1'b0, 2'd2, 18'h30000, 1'b0, "R1 high unaffected");
    // R5: writes to DRAM, reads back to ROM
    set_attr(3'd4, 2'b10);
    probe(1'b1, 32'h000F_0000, 1'b0, 2'd2, 18'h30000, 1'b0, "R5 R9");
    probe(1'b1, 32'h000F_0010, 1'b1, 2'd1, 18'h0, 1'b0, "R5 R7");
    set_attr(3'd4, 2'b11);
    probe(1'b1, 32'h000F_2000, 1'b0, 2'd1, 18'h0, 1'b0, "R4");
    probe(1'b1, 32'h000F_2000, 1'b1, 2'd1, 18'h0, 1'b0, "R5");
    probe(1'b1, 32'hFFFF_2000, 1'b1, 2'd2, 18'h32000, 1'b1, "R7 high");
    probe(1'b0, 32'h000F_2000, 1'b1, 2'd0, 18'h0, 1'b0, "R10");

    // R6: read-only control variant, sub-range 0 untouched
    probe_ro(32'h000E_0000, 1'b1, 2'd1, 1'b0, "R6");
    probe_ro(32'h000E_0000, 1'b0, 2'd2, 1'b0, "R6");
    probe_ro(32'h000F_0000, 1'b0, 2'd1, 1'b0, "R6");
    probe_ro(32'hFFFF_FFF0, 1'b1, 2'd2, 1'b1, "R6 R7");

    // R9: reset clears attributes again
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    probe(1'b1, 32'h000F_0000, 1'b0, 2'd2, 18'h30000, 1'b0, "R3 after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule